// File: doc/BRIEF.md
# Command-to-Flit Packet Serializer

This block turns bus-style command transactions into packets of 40-bit network flits. Each command arrives on a valid/ready channel one beat at a time. A beat carries an address, a transaction type, a burst length, a source identifier, a thread identifier, byte enables, a write data word and an end-of-packet marker. On the first beat the block captures the header fields and emits an address flit, then a control flit. For write-class commands the write data words follow as data flits, one per beat. The last flit of each packet carries an in-band end-of-packet bit in bit 39.

The serializer handles one packet at a time. It holds the first beat in registers while the two header flits drain. After that it passes the remaining beats into a single registered output stage, and that stage stalls cleanly under downstream backpressure. A new command is taken only once the last flit of the packet before it has left the block. The address and source widths are parameters. Both fields are left-aligned in their flit slots, with zeros below them.

Top module: `noc_cmd_packer`

## Requirements
- R1: A read-class command produces exactly two flits and consumes exactly one input beat. The read class is every type whose low three bits are 000, 001, 010, 011 (the four plain reads) or 110 (linked load).
- R2: A write-class command of N beats produces N+2 flits, with the data flits in beat order. The write class is type low bits 100 (write), 111 (store-conditional) and 101 (compare-and-swap).
- R3: The address flit has bit 39 = 0 and bit 0 = 0. Bits 38..1 hold bits 39..2 of the address after it is left-aligned to 40 bits with zeros below it. For the default 32-bit address, bits 38..7 equal the address and bits 6..1 are zero.
- R4: The control flit holds these fields:
  - bit 39: end-of-packet, which is 1 for the read class and 0 for the write class
  - bits 38..25: source field
  - bits 24..23: command code
  - bits 22..21: zero
  - bits 20..13: length
  - bits 12..9: thread id
  - bits 8..5: the 4-bit type
  - bits 4..1: the first beat's byte enables
  - bit 0: zero
- R5: Each data flit holds these fields:
  - bit 39: end-of-packet, which is 1 only on the flit from the beat marked last
  - bits 38..36: zero
  - bits 35..32: that beat's byte enables
  - bits 31..0: that beat's write data
- R6: A source id narrower than 14 bits sits at the top of the source field, with zeros below it. For the default 10-bit id this means bits 38..29 carry the id and bits 28..25 are zero.
- R7: The command code comes from the type's low three bits: 01 for the four plain reads, 10 for write, 11 for linked load, and 00 for store-conditional and compare-and-swap. The type's top bit is forwarded unchanged in the control flit but has no effect on class, command code or flit count.
- R8: While the output is valid and not accepted, it stays valid and the flit stays unchanged. Under any backpressure pattern no flit is lost or repeated.
- R9: The first beat of a new command is accepted only in a cycle after the final flit of the previous packet has been handed off. While header flits are pending, input ready stays low.
- R10: After reset the output is not valid and the input is ready.
- R11: Idle cycles between the beats of a write burst are allowed. The data flits still come out complete and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Input beat valid |
| reqReady | output | 1 | Input beat accepted when high with reqValid |
| reqAddr | input | ADDR_W | Command address (first beat) |
| reqType | input | 4 | Transaction type; low three bits decoded |
| reqPlen | input | 8 | Burst length in bytes (first beat) |
| reqSrcId | input | SRCID_W | Source identifier (first beat) |
| reqTrdId | input | 4 | Thread identifier (first beat) |
| reqBe | input | 4 | Byte enables of this beat |
| reqData | input | 32 | Write data of this beat |
| reqEop | input | 1 | Marks the last beat of a command |
| outValid | output | 1 | Output flit valid |
| outReady | input | 1 | Downstream accepts the flit |
| outFlit | output | 40 | Output flit |

## Verification
The assertions take for granted that the input side obeys valid/ready rules. A presented beat stays unchanged until it is accepted. A read-class command is sent as one beat marked last. Write bursts end with exactly one beat marked last. The stimulus tasks keep to this: they hold each beat until ready is seen, they drive reads as single last beats, and they mark only the final beat of each write. Between beats they vary downstream readiness and insert idle gaps.

// File: rtl/nocp_pkg.sv
package nocp_pkg;

  localparam int FLIT_W      = 40;
  localparam int SRC_FIELD_W = 14;
  localparam int ADDR_FLD_W  = 38;
  localparam int DATA_W      = 32;
  localparam int BE_W        = 4;
  localparam int TYPE_W      = 4;
  localparam int PLEN_W      = 8;
  localparam int TRD_W       = 4;

  typedef logic [FLIT_W-1:0]      flit_t;
  typedef logic [SRC_FIELD_W-1:0] srcField_t;
  typedef logic [ADDR_FLD_W-1:0]  addrField_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_DATA,
    ST_BEAT
  } seqState_t;

  typedef struct packed {
    logic captureHdr;
    logic loadAddr;
    logic loadCtrl;
    logic loadDataHeld;
    logic loadDataLive;
    logic clearOut;
  } ctrlStrobe_t;

  function automatic logic typeIsWrite(input logic [2:0] kind);
    return (kind == 3'b100) || (kind == 3'b101) || (kind == 3'b111);
  endfunction

  function automatic logic [1:0] typeCmd(input logic [2:0] kind);
    logic [1:0] code;
    unique case (kind)
      3'b100:  code = 2'b10;
      3'b110:  code = 2'b11;
      3'b101,
      3'b111:  code = 2'b00;
      default: code = 2'b01;
    endcase
    return code;
  endfunction

  function automatic flit_t buildAddrFlit(input addrField_t word);
    return {1'b0, word, 1'b0};
  endfunction

  function automatic flit_t buildCtrlFlit(
    input logic              last,
    input srcField_t         src,
    input logic [1:0]        cmd,
    input logic [PLEN_W-1:0] plen,
    input logic [TRD_W-1:0]  trd,
    input logic [TYPE_W-1:0] kind,
    input logic [BE_W-1:0]   be
  );
    return {last, src, cmd, 2'b00, plen, trd, kind, be, 1'b0};
  endfunction

  function automatic flit_t buildDataFlit(
    input logic              last,
    input logic [BE_W-1:0]   be,
    input logic [DATA_W-1:0] data
  );
    return {last, 3'b000, be, data};
  endfunction

endpackage

// File: rtl/nocp_datapath.sv
module nocp_datapath
  import nocp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SRCID_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic               outReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [TYPE_W-1:0]  reqType,
  input  logic [PLEN_W-1:0]  reqPlen,
  input  logic [SRCID_W-1:0] reqSrcId,
  input  logic [TRD_W-1:0]   reqTrdId,
  input  logic [BE_W-1:0]    reqBe,
  input  logic [DATA_W-1:0]  reqData,
  input  logic               reqEop,
  output logic               outValid,
  output flit_t              outFlit,
  output logic               hdrWrite,
  output logic               heldEop
);

  localparam int ADDR_SHIFT = FLIT_W - ADDR_W;
  localparam int SRC_SHIFT  = SRC_FIELD_W - SRCID_W;

  addrField_t        addrWord;
  srcField_t         srcAligned;
  srcField_t         hdrSrc;
  logic [1:0]        hdrCmd;
  logic [PLEN_W-1:0] hdrPlen;
  logic [TRD_W-1:0]  hdrTrd;
  logic [TYPE_W-1:0] hdrType;
  logic [BE_W-1:0]   hdrBe;
  logic [BE_W-1:0]   heldBe;
  logic [DATA_W-1:0] heldData;

  // Left-align the address in 40 bits, then drop the two lowest bits.
  assign addrWord   = addrField_t'((flit_t'(reqAddr) << ADDR_SHIFT) >> 2);
  assign srcAligned = srcField_t'(srcField_t'(reqSrcId) << SRC_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrSrc   <= '0;
      hdrCmd   <= '0;
      hdrPlen  <= '0;
      hdrTrd   <= '0;
      hdrType  <= '0;
      hdrBe    <= '0;
      hdrWrite <= 1'b0;
      heldBe   <= '0;
      heldData <= '0;
      heldEop  <= 1'b0;
    end else if (strb.captureHdr) begin
      hdrSrc   <= srcAligned;
      hdrCmd   <= typeCmd(reqType[2:0]);
      hdrPlen  <= reqPlen;
      hdrTrd   <= reqTrdId;
      hdrType  <= reqType;
      hdrBe    <= reqBe;
      hdrWrite <= typeIsWrite(reqType[2:0]);
      heldBe   <= reqBe;
      heldData <= reqData;
      heldEop  <= reqEop;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outFlit  <= '0;
    end else begin
      if (strb.loadAddr) begin
        outFlit  <= buildAddrFlit(addrWord);
        outValid <= 1'b1;
      end else if (strb.loadCtrl) begin
        outFlit  <= buildCtrlFlit(~hdrWrite, hdrSrc, hdrCmd, hdrPlen, hdrTrd, hdrType, hdrBe);
        outValid <= 1'b1;
      end else if (strb.loadDataHeld) begin
        outFlit  <= buildDataFlit(heldEop, heldBe, heldData);
        outValid <= 1'b1;
      end else if (strb.loadDataLive) begin
        outFlit  <= buildDataFlit(reqEop, reqBe, reqData);
        outValid <= 1'b1;
      end else if (strb.clearOut) begin
        outValid <= 1'b0;
      end
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outFlit))); // R8

endmodule

// File: rtl/nocp_control.sv
module nocp_control
  import nocp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        outReady,
  input  logic        outValid,
  input  logic        outEop,
  input  logic        hdrWrite,
  input  logic        heldEop,
  output logic        reqReady,
  output ctrlStrobe_t strb
);

  seqState_t state;
  seqState_t stateNext;
  logic      outFire;

  assign outFire = outValid && outReady;

  always_comb begin
    stateNext = state;
    reqReady  = 1'b0;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.captureHdr = 1'b1;
          strb.loadAddr   = 1'b1;
          stateNext       = ST_ADDR;
        end
      end
      ST_ADDR: begin
        if (outFire) begin
          strb.loadCtrl = 1'b1;
          stateNext     = ST_CTRL;
        end
      end
      ST_CTRL: begin
        if (outFire) begin
          if (hdrWrite) begin
            strb.loadDataHeld = 1'b1;
            stateNext         = ST_DATA;
          end else begin
            strb.clearOut = 1'b1;
            stateNext     = ST_IDLE;
          end
        end
      end
      ST_DATA: begin
        if (outEop) begin
          if (outFire) begin
            strb.clearOut = 1'b1;
            stateNext     = ST_IDLE;
          end
        end else begin
          reqReady = outReady;
          if (outFire) begin
            if (reqValid) begin
              strb.loadDataLive = 1'b1;
            end else begin
              strb.clearOut = 1'b1;
              stateNext     = ST_BEAT;
            end
          end
        end
      end
      ST_BEAT: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.loadDataLive = 1'b1;
          stateNext         = ST_DATA;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadAddr, strb.loadCtrl, strb.loadDataHeld, strb.loadDataLive, strb.clearOut})); // R8
  AST_HDR_ONLY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureHdr |-> !outValid); // R9
  AST_EMPTY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outEop) |=> !outValid); // R9
  AST_ADDR_FLIT_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ADDR) |-> (outValid && !outEop)); // R3
  AST_READ_CTRL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CTRL && !hdrWrite) |-> outEop); // R1
  AST_WRITE_CTRL_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CTRL && hdrWrite) |-> !outEop); // R4
  AST_HELD_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CTRL && hdrWrite && outReady) |=> (outEop == $past(heldEop))); // R5

endmodule

// File: rtl/noc_cmd_packer.sv
module noc_cmd_packer
  import nocp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SRCID_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [3:0]         reqType,
  input  logic [7:0]         reqPlen,
  input  logic [SRCID_W-1:0] reqSrcId,
  input  logic [3:0]         reqTrdId,
  input  logic [3:0]         reqBe,
  input  logic [31:0]        reqData,
  input  logic               reqEop,
  output logic               outValid,
  input  logic               outReady,
  output logic [39:0]        outFlit
);

  ctrlStrobe_t strb;
  logic        hdrWrite;
  logic        heldEop;

  nocp_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .outReady (outReady),
    .outValid (outValid),
    .outEop   (outFlit[FLIT_W-1]),
    .hdrWrite (hdrWrite),
    .heldEop  (heldEop),
    .reqReady (reqReady),
    .strb     (strb)
  );

  nocp_datapath #(
    .ADDR_W  (ADDR_W),
    .SRCID_W (SRCID_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .outReady (outReady),
    .reqAddr  (reqAddr),
    .reqType  (reqType),
    .reqPlen  (reqPlen),
    .reqSrcId (reqSrcId),
    .reqTrdId (reqTrdId),
    .reqBe    (reqBe),
    .reqData  (reqData),
    .reqEop   (reqEop),
    .outValid (outValid),
    .outFlit  (outFlit),
    .hdrWrite (hdrWrite),
    .heldEop  (heldEop)
  );

endmodule

// File: tb/noc_cmd_packer_tb_top.sv
`timescale 1ns/1ps
module noc_cmd_packer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqType = '0;
  logic [7:0]  reqPlen = '0;
  logic [9:0]  reqSrcId = '0;
  logic [3:0]  reqTrdId = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] reqData = '0;
  logic        reqEop = 1'b0;
  logic        outValid;
  logic        outReady = 1'b1;
  logic [39:0] outFlit;

  int          testsRun = 0;
  int          testsFailed = 0;
  int          cyc = 0;
  int          bpMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic [39:0] expFlit [0:63];
  logic [39:0] gotFlit [0:63];
  int          expCount = 0;
  int          gotCount = 0;
  int          hdrCyc [0:7];
  int          eopCyc [0:7];
  int          hdrN = 0;
  int          eopN = 0;
  bit          prevStall = 1'b0;
  logic [39:0] prevFlit = '0;

  noc_cmd_packer dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqType(reqType), .reqPlen(reqPlen), .reqSrcId(reqSrcId),
    .reqTrdId(reqTrdId), .reqBe(reqBe), .reqData(reqData), .reqEop(reqEop),
    .outValid(outValid), .outReady(outReady), .outFlit(outFlit)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (bpMode == 0)      outReady <= 1'b1;
    else if (bpMode == 1) outReady <= lfsr[0];
    else                  outReady <= (lfsr[1:0] == 2'b00);
  end

  task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: samples 1 ns before each rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (rstN) begin
        if (prevStall)
          chk(outValid && (outFlit == prevFlit), "R8 flit held under stall", outFlit, prevFlit);
        prevStall = outValid && !outReady;
        prevFlit  = outFlit;
        if (outValid && outReady) begin
          if (gotCount < 64) gotFlit[gotCount] = outFlit;
          gotCount++;
          if (outFlit[39] && eopN < 8) begin
            eopCyc[eopN] = cyc;
            eopN++;
          end
        end
      end
    end
  end

  function automatic bit isReadType(input logic [3:0] t);
    return (t[2] == 1'b0) || (t[2:0] == 3'b110);
  endfunction

  function automatic logic [1:0] expCmd(input logic [3:0] t);
    case (t[2:0])
      3'd0, 3'd1, 3'd2, 3'd3: return 2'b01;
      3'd4:                   return 2'b10;
      3'd6:                   return 2'b11;
      default:                return 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] beatBe(input int i);
    return 4'hF ^ 4'(i);
  endfunction

  task automatic pushExp(input logic [39:0] f);
    expFlit[expCount] = f;
    expCount++;
  endtask

  task automatic clearBoard();
    expCount = 0; gotCount = 0; hdrN = 0; eopN = 0;
  endtask

  task automatic driveBeat(input logic [3:0] typ, input logic [31:0] addr, input logic [9:0] src,
                           input logic [3:0] trd, input logic [7:0] plen, input logic [3:0] be,
                           input logic [31:0] data, input bit last, input bit first, input int gap);
    repeat (gap) @(negedge clk);
    reqValid = 1'b1; reqType = typ; reqAddr = addr; reqSrcId = src; reqTrdId = trd;
    reqPlen = plen; reqBe = be; reqData = data; reqEop = last;
    forever begin
      #4;
      if (reqReady) begin
        if (first && hdrN < 8) begin
          hdrCyc[hdrN] = cyc;
          hdrN++;
        end
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    reqValid = 1'b0;
  endtask

  task automatic runPacket(input logic [3:0] typ, input logic [31:0] addr, input logic [9:0] src,
                           input logic [3:0] trd, input int nBeats, input int gap);
    bit rd = isReadType(typ);
    int beats = rd ? 1 : nBeats;
    logic [7:0] plen = 8'(beats * 4);
    logic [39:0] f;
    f = '0; f[38:7] = addr;
    pushExp(f);
    f = '0;
    f[39] = rd; f[38:29] = src; f[24:23] = expCmd(typ); f[20:13] = plen;
    f[12:9] = trd; f[8:5] = typ; f[4:1] = beatBe(0);
    pushExp(f);
    if (!rd) begin
      for (int i = 0; i < beats; i++) begin
        f = '0; f[39] = (i == beats - 1); f[35:32] = beatBe(i); f[31:0] = addr ^ 32'(i * 32'h01010101);
        pushExp(f);
      end
    end
    for (int i = 0; i < beats; i++)
      driveBeat(typ, addr, src, trd, plen, beatBe(i), addr ^ 32'(i * 32'h01010101),
                (i == beats - 1), (i == 0), (i == 0) ? 0 : gap);
  endtask

  task automatic waitAndCompare(input string tag);
    int t = 0;
    while (gotCount < expCount && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    chk(gotCount == expCount, {tag, " flit count"}, 40'(gotCount), 40'(expCount));
    for (int i = 0; i < expCount && i < gotCount; i++)
      chk(gotFlit[i] == expFlit[i], $sformatf("%s flit %0d", tag, i), gotFlit[i], expFlit[i]);
  endtask

  task automatic testReset();
    @(negedge clk);
    #4;
    chk(outValid == 1'b0, "R10 no output after reset", 40'(outValid), 40'(0));
    chk(reqReady == 1'b1, "R10 ready after reset", 40'(reqReady), 40'(1));
    @(negedge clk);
  endtask

  task automatic testReadTypes();
    logic [3:0] kinds [0:4] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd6};
    for (int k = 0; k < 5; k++) begin
      clearBoard();
      runPacket(kinds[k], 32'h8000_0000 | 32'(k * 32'h1234_5670), 10'h3FF - 10'(k), 4'(k + 3), 1, 0);
      waitAndCompare($sformatf("R1 R3 R4 R6 R7 read type %0d", k));
    end
  endtask

  task automatic testTypeMsb();
    clearBoard();
    runPacket(4'b1001, 32'hDEAD_BEEF, 10'h155, 4'hA, 1, 0);
    waitAndCompare("R7 type top bit ignored (read)");
    clearBoard();
    runPacket(4'b1100, 32'h1357_9BDF, 10'h2AA, 4'h5, 3, 0);
    waitAndCompare("R7 type top bit ignored (write)");
  endtask

  task automatic testWriteTypes();
    clearBoard();
    runPacket(4'd4, 32'h0000_1000, 10'h001, 4'h1, 1, 0);
    waitAndCompare("R2 R5 single-beat write");
    clearBoard();
    runPacket(4'd4, 32'hFFFF_FFFC, 10'h200, 4'h2, 4, 0);
    waitAndCompare("R2 R5 four-beat write");
    clearBoard();
    runPacket(4'd7, 32'h4000_0040, 10'h0F0, 4'h3, 2, 0);
    waitAndCompare("R2 R7 store-conditional");
    clearBoard();
    runPacket(4'd5, 32'h2000_0080, 10'h30F, 4'h4, 2, 0);
    waitAndCompare("R2 R7 compare-and-swap");
  endtask

  task automatic testStalls();
    bpMode = 1;
    clearBoard();
    runPacket(4'd4, 32'hCAFE_0000, 10'h111, 4'h6, 16, 0);
    runPacket(4'd1, 32'hCAFE_0100, 10'h222, 4'h7, 1, 0);
    waitAndCompare("R8 random backpressure");
    bpMode = 2;
    clearBoard();
    runPacket(4'd7, 32'hBEEF_0010, 10'h333, 4'h8, 2, 0);
    waitAndCompare("R8 heavy backpressure");
    bpMode = 0;
  endtask

  task automatic testBeatGaps();
    clearBoard();
    runPacket(4'd4, 32'h0F0F_0F00, 10'h0AA, 4'h9, 5, 3);
    waitAndCompare("R11 idle gaps between beats");
    bpMode = 1;
    clearBoard();
    runPacket(4'd4, 32'h7070_7000, 10'h0BB, 4'hB, 4, 2);
    waitAndCompare("R11 gaps with backpressure");
    bpMode = 0;
  endtask

  task automatic testBackToBack();
    bpMode = 2;
    clearBoard();
    runPacket(4'd4, 32'h1111_0000, 10'h011, 4'hC, 3, 0);
    runPacket(4'd0, 32'h2222_0000, 10'h022, 4'hD, 1, 0);
    runPacket(4'd6, 32'h3333_0000, 10'h033, 4'hE, 1, 0);
    waitAndCompare("R9 back-to-back packets");
    chk(hdrCyc[1] > eopCyc[0], "R9 second command waits for last flit", 40'(hdrCyc[1]), 40'(eopCyc[0]));
    chk(hdrCyc[2] > eopCyc[1], "R9 third command waits for last flit", 40'(hdrCyc[2]), 40'(eopCyc[1]));
    bpMode = 0;
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testReadTypes();
    testTypeMsb();
    testWriteTypes();
    testStalls();
    testBeatGaps();
    testBackToBack();
    finishRun();
  end

endmodule